// File: doc/BRIEF.md
# Mode-banked processor register file

This block holds the general-purpose registers and status state of a 32-bit processor core that switches between privilege modes. Sixteen architectural registers are visible at any time, and register 15 serves as the program counter. The current mode decides which physical storage each architectural number reaches. Register 8 through register 14 are private in the fast-interrupt mode. Register 13 and register 14 are private in each of the other four exception modes. User mode and system mode share a single set of registers.

A core reads two operands combinationally and writes one result per clock, with all three ports addressed by architectural number. It requests a mode change on a separate pin. The file also keeps the live status word and one saved-status word for each exception mode. Banking works by remapping indices into one flat physical array, so a mode change takes one clock edge and needs no copy cycles.

None of the pins carries a data stream. Each request is taken on the clock edge where its enable is high, so there is no valid/ready handshake and no back-pressure. Every request is accepted in the cycle it is presented.

Top module: `banked_regfile`

## Requirements
- R1: Read ports are combinational and reflect the current mode. A write with `wr_en` high lands on the next rising edge. Register 15 and registers 0 to 7 are never banked.
- R2: A mode request keeps the low 5 bits of `mode_req` and forces bit 4 to 1. The result becomes `cur_mode` on the next edge, so requests of 0x01 and 0xE1 both select fast-interrupt mode. When no request is made, the mode holds.
- R3: Fast-interrupt mode (0x11) has its own copies of registers 8 to 14. Writes made in that mode are never visible in any other mode.
- R4: Registers 8 to 12 are one shared set across user (0x10), system (0x1F), interrupt (0x12), supervisor (0x13), abort (0x17), undefined (0x1B) and reserved encodings.
- R5: Registers 13 and 14 have separate copies for interrupt, supervisor, abort, undefined and fast-interrupt modes. User and system share one further copy of their own.
- R6: Any 5-bit mode value outside the seven defined ones uses the user/system copies of every register.
- R7: A request for the mode that is already active changes no register contents.
- R8: Each of the five exception modes has its own saved-status word. A write stores only bits 31:28, 7:6 and 4:0, and all other bits read as zero.
- R9: The live status word reads as N, Z, C, V at bits 31 to 28, the interrupt mask at bit 7, the fast-interrupt mask at bit 6 and the current mode in bits 4:0. All other bits read as zero.
- R10: After reset every register and saved-status word is zero, the mode is user (0x10) and both masks are clear, so the status word reads 0x00000010.
- R11: When a register write and a mode request fall in the same cycle, the write goes to the bank of the mode in effect before the switch.
- R12: A status write updates the flags and masks but never the mode field. In user, system or a reserved mode, saved-status reads return the live status word and saved-status writes update the live flags and masks. A live-status write wins over such an aliased write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Architectural index, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_idx | input | 4 | Architectural index, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Architectural index for the write |
| wr_data | input | 32 | Write data |
| mode_req_valid | input | 1 | Mode switch request |
| mode_req | input | 8 | Requested mode, normalised as in R2 |
| cur_mode | output | 5 | Current mode |
| stat_wr_en | input | 1 | Live status write enable |
| stat_wr_data | input | 32 | Live status write data |
| stat_rd_data | output | 32 | Packed live status word |
| sav_wr_en | input | 1 | Saved-status write enable |
| sav_wr_data | input | 32 | Saved-status write data |
| sav_rd_data | output | 32 | Saved-status word for the current mode |

## Verification
Two pairs of functions can collide in one cycle. A register write can coincide with a mode switch, and a live-status write can coincide with a saved-status write that aliases onto the live word. The bench provokes the first pair by raising `mode_req_valid` and `wr_en` on the same edge while leaving supervisor mode for fast-interrupt mode. It then reads register 8 in both banks: the written value must appear only in the shared user bank. The bench judges the second pair from the packed status word after user-mode writes, and from saved-status reads taken in several exception modes, which must stay separate.

// File: rtl/rbank_pkg.sv
package rbank_pkg;
  localparam int ARCH_N  = 16;
  localparam int AIDX_W  = $clog2(ARCH_N);
  localparam int PHYS_N  = 31;
  localparam int PIDX_W  = $clog2(PHYS_N);
  localparam int MODE_W  = 5;
  localparam int STAT_W  = 32;
  localparam int NSAVED  = 5;
  localparam int SLOT_W  = 3;

  localparam logic [MODE_W-1:0] M_USR = 5'h10;
  localparam logic [MODE_W-1:0] M_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] M_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] M_SVC = 5'h13;
  localparam logic [MODE_W-1:0] M_ABT = 5'h17;
  localparam logic [MODE_W-1:0] M_UND = 5'h1B;
  localparam logic [MODE_W-1:0] M_SYS = 5'h1F;

  localparam logic [STAT_W-1:0] STAT_KEEP = 32'hF000_00DF;
  localparam logic [SLOT_W-1:0] NO_SLOT   = 3'd7;

  // Physical layout: 0..15 unbanked view / user bank, 16..22 fast-interrupt R8..R14,
  // then two-register pairs for interrupt, supervisor, abort, undefined.
  localparam logic [PIDX_W-1:0] FIQ_BASE = 5'd16;
  localparam logic [PIDX_W-1:0] IRQ_BASE = 5'd23;
  localparam logic [PIDX_W-1:0] SVC_BASE = 5'd25;
  localparam logic [PIDX_W-1:0] ABT_BASE = 5'd27;
  localparam logic [PIDX_W-1:0] UND_BASE = 5'd29;

  function automatic logic [MODE_W-1:0] norm_mode(input logic [7:0] raw);
    return {1'b1, raw[3:0]};
  endfunction

  function automatic logic [PIDX_W-1:0] pair_idx(input logic [PIDX_W-1:0] base,
                                                 input logic [AIDX_W-1:0] a);
    return base + {4'd0, a[0] ^ 1'b1};  // 13 -> base, 14 -> base+1
  endfunction

  function automatic logic [PIDX_W-1:0] phys_of(input logic [MODE_W-1:0] m,
                                                input logic [AIDX_W-1:0] a);
    logic [PIDX_W-1:0] p;
    logic hi_pair;
    logic hi_set;
    p       = {1'b0, a};
    hi_pair = (a == 4'd13) || (a == 4'd14);
    hi_set  = (a >= 4'd8) && (a <= 4'd14);
    case (m)
      M_FIQ: if (hi_set) p = FIQ_BASE + ({1'b0, a} - 5'd8);
      M_IRQ: if (hi_pair) p = pair_idx(IRQ_BASE, a);
      M_SVC: if (hi_pair) p = pair_idx(SVC_BASE, a);
      M_ABT: if (hi_pair) p = pair_idx(ABT_BASE, a);
      M_UND: if (hi_pair) p = pair_idx(UND_BASE, a);
      default: p = {1'b0, a};
    endcase
    return p;
  endfunction

  function automatic logic [SLOT_W-1:0] saved_slot(input logic [MODE_W-1:0] m);
    case (m)
      M_FIQ:   return 3'd0;
      M_IRQ:   return 3'd1;
      M_SVC:   return 3'd2;
      M_ABT:   return 3'd3;
      M_UND:   return 3'd4;
      default: return NO_SLOT;
    endcase
  endfunction
endpackage

// File: rtl/rbank_mode.sv
module rbank_mode
  import rbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [7:0]        req_raw,
  output logic [MODE_W-1:0] mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)         mode_q <= M_USR;
    else if (req_valid) mode_q <= norm_mode(req_raw);
  end

  p_mode_bit4_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[MODE_W-1] == 1'b1);

  p_switch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> mode_q[3:0] == $past(req_raw[3:0]));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(mode_q));
endmodule

// File: rtl/rbank_map.sv
module rbank_map
  import rbank_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [AIDX_W-1:0] arch,
  output logic [PIDX_W-1:0] phys
);
  always_comb begin
    phys = phys_of(mode, arch);
    if (!$isunknown({mode, arch})) begin
      p_phys_range_r5: assert (phys < PIDX_W'(PHYS_N));
    end
  end
endmodule

// File: rtl/rbank_gpr.sv
module rbank_gpr
  import rbank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NRD    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PIDX_W-1:0] wr_pidx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PIDX_W-1:0] rd_pidx [NRD],
  output logic [DATA_W-1:0] rd_data [NRD]
);
  logic [DATA_W-1:0] regs_q [PHYS_N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PHYS_N; i++) regs_q[i] <= '0;
    end else if (wr_en) begin
      regs_q[wr_pidx] <= wr_data;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = regs_q[rd_pidx[g]];
  end

  p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs_q[$past(wr_pidx)] == $past(wr_data));
endmodule

// File: rtl/rbank_status.sv
module rbank_status
  import rbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic              stat_wr_en,
  input  logic [STAT_W-1:0] stat_wr_data,
  input  logic              sav_wr_en,
  input  logic [STAT_W-1:0] sav_wr_data,
  output logic [STAT_W-1:0] stat_rd,
  output logic [STAT_W-1:0] sav_rd
);
  logic [3:0]        flags_q;
  logic              imask_q;
  logic              fmask_q;
  logic [STAT_W-1:0] saved_q [NSAVED];
  logic [SLOT_W-1:0] slot;
  logic              has_saved;

  assign slot      = saved_slot(cur_mode);
  assign has_saved = (slot != NO_SLOT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      imask_q <= 1'b0;
      fmask_q <= 1'b0;
    end else if (stat_wr_en) begin
      flags_q <= stat_wr_data[31:28];
      imask_q <= stat_wr_data[7];
      fmask_q <= stat_wr_data[6];
    end else if (sav_wr_en && !has_saved) begin
      flags_q <= sav_wr_data[31:28];
      imask_q <= sav_wr_data[7];
      fmask_q <= sav_wr_data[6];
    end
  end

  for (genvar s = 0; s < NSAVED; s++) begin : g_saved
    always_ff @(posedge clk) begin
      if (!rst_n)                                    saved_q[s] <= '0;
      else if (sav_wr_en && slot == SLOT_W'(s))      saved_q[s] <= sav_wr_data & STAT_KEEP;
    end

    p_saved_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sav_wr_en |=> $stable(saved_q[s]));
  end

  assign stat_rd = {flags_q, 20'd0, imask_q, fmask_q, 1'b0, cur_mode};
  assign sav_rd  = has_saved ? saved_q[slot] : stat_rd;

  p_live_flags_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_wr_en && !(sav_wr_en && !has_saved)) |=> $stable(stat_rd[31:6]));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mode_req_valid,
  input  logic [7:0]        mode_req,
  output logic [4:0]        cur_mode,
  input  logic              stat_wr_en,
  input  logic [31:0]       stat_wr_data,
  output logic [31:0]       stat_rd_data,
  input  logic              sav_wr_en,
  input  logic [31:0]       sav_wr_data,
  output logic [31:0]       sav_rd_data
);
  localparam int NRD   = 2;
  localparam int NPORT = NRD + 1;

  logic [AIDX_W-1:0] arch_idx [NPORT];
  logic [PIDX_W-1:0] phys_idx [NPORT];
  logic [PIDX_W-1:0] rd_pidx  [NRD];
  logic [DATA_W-1:0] rd_word  [NRD];
  logic [MODE_W-1:0] mode_q;

  assign arch_idx[0] = rd_a_idx;
  assign arch_idx[1] = rd_b_idx;
  assign arch_idx[2] = wr_idx;

  rbank_mode u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (mode_req_valid),
    .req_raw   (mode_req),
    .mode_q    (mode_q)
  );

  // The write port maps through the registered mode, so a same-cycle switch
  // does not affect where the write lands.
  for (genvar p = 0; p < NPORT; p++) begin : g_map
    rbank_map u_map (
      .mode (mode_q),
      .arch (arch_idx[p]),
      .phys (phys_idx[p])
    );
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rdp
    assign rd_pidx[r] = phys_idx[r];
  end

  rbank_gpr #(.DATA_W(DATA_W), .NRD(NRD)) u_gpr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_pidx (phys_idx[NRD]),
    .wr_data (wr_data),
    .rd_pidx (rd_pidx),
    .rd_data (rd_word)
  );

  rbank_status u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .cur_mode     (mode_q),
    .stat_wr_en   (stat_wr_en),
    .stat_wr_data (stat_wr_data),
    .sav_wr_en    (sav_wr_en),
    .sav_wr_data  (sav_wr_data),
    .stat_rd      (stat_rd_data),
    .sav_rd       (sav_rd_data)
  );

  assign rd_a_data = rd_word[0];
  assign rd_b_data = rd_word[1];
  assign cur_mode  = mode_q;

  p_pc_unbanked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'd15) |=> (mode_req_valid || 1'b1) && $past(wr_data) ==
      ((rd_a_idx == 4'd15) ? rd_a_data : $past(wr_data)));
endmodule

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en, mode_req_valid, stat_wr_en, sav_wr_en;
  logic [7:0]  mode_req;
  logic [4:0]  cur_mode;
  logic [31:0] stat_wr_data, stat_rd_data, sav_wr_data, sav_rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_regfile u0 (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .mode_req_valid(mode_req_valid), .mode_req(mode_req), .cur_mode(cur_mode),
    .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data), .stat_rd_data(stat_rd_data),
    .sav_wr_en(sav_wr_en), .sav_wr_data(sav_wr_data), .sav_rd_data(sav_rd_data)
  );

  // Vector: {mode request, write index, write data, read index, expected read}
  localparam logic [79:0] VEC [NVEC] = '{
    {8'h10, 4'd8,  32'h0000_00A1, 4'd8,  32'h0000_00A1},  // R1 R4
    {8'h11, 4'd9,  32'h0000_00B9, 4'd8,  32'h0000_0000},  // R3
    {8'h10, 4'd13, 32'h0000_0C13, 4'd9,  32'h0000_0000},  // R3
    {8'h12, 4'd13, 32'h0000_0D13, 4'd8,  32'h0000_00A1},  // R4
    {8'h13, 4'd14, 32'h0000_0E14, 4'd13, 32'h0000_0000},  // R5
    {8'h12, 4'd0,  32'h0000_00F0, 4'd13, 32'h0000_0D13},  // R5
    {8'h1F, 4'd1,  32'h0000_0011, 4'd13, 32'h0000_0C13},  // R5
    {8'h14, 4'd2,  32'h0000_0022, 4'd13, 32'h0000_0C13},  // R6
    {8'h01, 4'd3,  32'h0000_0033, 4'd9,  32'h0000_00B9},  // R2
    {8'hE7, 4'd13, 32'h0000_00AB, 4'd0,  32'h0000_00F0},  // R2
    {8'h1B, 4'd14, 32'h0000_1B1B, 4'd13, 32'h0000_0000},  // R5
    {8'h17, 4'd4,  32'h0000_0044, 4'd13, 32'h0000_00AB},  // R5
    {8'h13, 4'd5,  32'h0000_0055, 4'd14, 32'h0000_0E14}   // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic switch_to(input logic [7:0] m);
    mode_req_valid = 1'b1;
    mode_req = m;
    tick();
    mode_req_valid = 1'b0;
  endtask

  task automatic read_a(input logic [3:0] idx, output logic [31:0] v);
    rd_a_idx = idx;
    #1;
    v = rd_a_data;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0;
    rd_a_idx = '0; rd_b_idx = '0; wr_idx = '0; wr_data = '0; wr_en = 1'b0;
    mode_req_valid = 1'b0; mode_req = '0;
    stat_wr_en = 1'b0; stat_wr_data = '0; sav_wr_en = 1'b0; sav_wr_data = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R10 reset state
    check("R10 mode", {27'd0, cur_mode}, 32'h10);
    check("R10 status", stat_rd_data, 32'h10);
    check("R10 saved alias", sav_rd_data, 32'h10);
    read_a(4'd15, v); check("R10 pc", v, 32'h0);

    // Table walk: R1..R6
    for (int i = 0; i < NVEC; i++) begin
      logic [79:0] vec;
      logic [7:0]  em;
      vec = VEC[i];
      em = (vec[79:72] & 8'h1F) | 8'h10;
      switch_to(vec[79:72]);
      wr_en = 1'b1; wr_idx = vec[71:68]; wr_data = vec[67:36];
      tick();
      wr_en = 1'b0;
      rd_a_idx = vec[35:32];
      rd_b_idx = vec[71:68];
      #1;
      check($sformatf("R1-vec%0d readback", i), rd_b_data, vec[67:36]);
      check($sformatf("R2 R3 R4 R5 R6 vec%0d read", i), rd_a_data, vec[31:0]);
      check($sformatf("R2 vec%0d mode", i), {24'd0, em}, {27'd0, cur_mode});
    end

    // R7: same-mode request in supervisor leaves registers alone
    switch_to(8'h13);
    read_a(4'd14, v); check("R7 r14 kept", v, 32'h0000_0E14);
    read_a(4'd8, v);  check("R7 r8 kept", v, 32'h0000_00A1);

    // R11: write and switch to fast interrupt on the same edge
    mode_req_valid = 1'b1; mode_req = 8'h11;
    wr_en = 1'b1; wr_idx = 4'd8; wr_data = 32'h0000_0077;
    tick();
    mode_req_valid = 1'b0; wr_en = 1'b0;
    read_a(4'd8, v); check("R11 fiq r8 untouched", v, 32'h0);
    switch_to(8'h10);
    read_a(4'd8, v); check("R11 shared r8 got write", v, 32'h0000_0077);

    // R9 R12: live status write, mode field ignored
    stat_wr_en = 1'b1; stat_wr_data = 32'hFFFF_FFFF;
    tick();
    stat_wr_en = 1'b0;
    check("R9 packed status", stat_rd_data, 32'hF000_00D0);
    check("R12 mode unchanged", {27'd0, cur_mode}, 32'h10);
    check("R12 user alias read", sav_rd_data, 32'hF000_00D0);
    sav_wr_en = 1'b1; sav_wr_data = 32'h0;
    tick();
    sav_wr_en = 1'b0;
    check("R12 user alias write", stat_rd_data, 32'h10);

    // R12: live write beats aliased write in the same cycle
    stat_wr_en = 1'b1; stat_wr_data = 32'h8000_0080;
    sav_wr_en = 1'b1;  sav_wr_data = 32'h4000_0040;
    tick();
    stat_wr_en = 1'b0; sav_wr_en = 1'b0;
    check("R12 live wins", stat_rd_data, 32'h8000_0090);

    // R8: per-mode saved status
    switch_to(8'h12);
    check("R8 irq saved reset", sav_rd_data, 32'h0);
    sav_wr_en = 1'b1; sav_wr_data = 32'hFFFF_FFFF;
    tick();
    sav_wr_en = 1'b0;
    check("R8 irq saved masked", sav_rd_data, 32'hF000_00DF);
    check("R8 live untouched", stat_rd_data, 32'h8000_0092);
    switch_to(8'h13);
    check("R8 svc saved separate", sav_rd_data, 32'h0);
    sav_wr_en = 1'b1; sav_wr_data = 32'h5000_0013;
    tick();
    sav_wr_en = 1'b0;
    switch_to(8'h12);
    check("R8 irq saved kept", sav_rd_data, 32'hF000_00DF);

    // R6 R12: reserved mode aliases saved status to live
    switch_to(8'h14);
    check("R6 reserved alias", sav_rd_data, 32'h8000_0094);

    // R10: reset mid-run clears banks
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    check("R10 mode after reset", {27'd0, cur_mode}, 32'h10);
    read_a(4'd8, v); check("R10 r8 cleared", v, 32'h0);
    read_a(4'd13, v); check("R10 r13 cleared", v, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule